// File: doc/BRIEF.md
# Burst Address Counter with Repeat

This block produces the internal address used for each access of a synchronous memory port. On every rising clock edge it picks the next address from one of four sources: the external address presented on the pins, the current address plus one, the current address unchanged, or a saved rewind address. The result appears at `addr_o` after that edge and stays there for the whole access cycle.

The rewind register captures every external address that is actually loaded. A burst can therefore be replayed from its first location with a single active-low control, without presenting the start address again. The controls act on their own and do not depend on whether the memory is selected. Before the first load, the rewind register holds no meaningful value. A rewind requested in that state is flagged on `rpt_err_o`.

Top module: `burst_addr_ctr`

## Requirements
- R1: If `rpt_ni`=1 and `ads_ni`=0 at a rising edge, `addr_o` equals the `ext_addr_i` sampled at that edge once the edge has passed.
- R2: If `rpt_ni`=1, `ads_ni`=1 and `cnt_en_ni`=0 at a rising edge, `addr_o` becomes its previous value plus one, and the all-ones address wraps to zero.
- R3: If `rpt_ni`, `ads_ni` and `cnt_en_ni` are all 1 at a rising edge, `addr_o` keeps its value and `ext_addr_i` has no effect.
- R4: If `rpt_ni`=0 at a rising edge and a load has happened since reset, `addr_o` becomes the address of the most recent load, whatever `ads_ni`, `cnt_en_ni` and `ext_addr_i` are. A strobe presented together with `rpt_ni`=0 loads nothing and leaves the rewind address unchanged.
- R5: Every load under R1 replaces the rewind address, so a later rewind returns to the newest loaded address.
- R6: `rpt_err_o` is 1 for the cycle after an edge that samples `rpt_ni`=0 with no load since reset. It is 0 after any other edge.
- R7: While `rst_ni`=0, `rpt_err_o` is 0. The validity of the rewind address is cleared, so a rewind after reset is flagged again until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_addr_i | input | AW | External address |
| ads_ni | input | 1 | Address strobe, active low |
| cnt_en_ni | input | 1 | Count enable, active low |
| rpt_ni | input | 1 | Rewind to last loaded address, active low |
| addr_o | output | AW | Internal address of the current access |
| rpt_err_o | output | 1 | Rewind requested before any load |

## Verification
The rewind assertion applies only once the validity flag is set. The address that follows a rewind issued with nothing loaded is left unconstrained, because it comes from the cleared reset value. The bench keeps to this rule by checking only the error flag in those cycles and never relying on the reset value of the address. All controls change at the falling edge, so every assertion samples stable, fully known inputs.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_INC  = 2'd1,
    SRC_LOAD = 2'd2,
    SRC_RPT  = 2'd3
  } addr_src_e;
endpackage

// File: rtl/bac_src_sel.sv
module bac_src_sel
  import bac_pkg::*;
(
  input  logic      ads_ni,
  input  logic      cnt_en_ni,
  input  logic      rpt_ni,
  output addr_src_e src_o
);
  // priority: rewind, strobe, count, hold
  always_comb begin
    if (!rpt_ni)         src_o = SRC_RPT;
    else if (!ads_ni)    src_o = SRC_LOAD;
    else if (!cnt_en_ni) src_o = SRC_INC;
    else                 src_o = SRC_HOLD;
  end
endmodule

// File: rtl/bac_rpt_reg.sv
module bac_rpt_reg #(
  parameter int AW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic          rpt_req_i,
  input  logic [AW-1:0] ext_addr_i,
  output logic [AW-1:0] rpt_addr_o,
  output logic          valid_o,
  output logic          err_o
);
  logic [AW-1:0] rpt_q;
  logic          valid_q;
  logic          err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rpt_q   <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (load_i) begin
        rpt_q   <= ext_addr_i;
        valid_q <= 1'b1;
      end
      err_q <= rpt_req_i && !valid_q;
    end
  end

  assign rpt_addr_o = rpt_q;
  assign valid_o    = valid_q;
  assign err_o      = err_q;

  AST_VALID_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> valid_q); // R5
  AST_RPT_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(rpt_q)); // R4
endmodule

// File: rtl/bac_addr_reg.sv
module bac_addr_reg
  import bac_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  addr_src_e     src_i,
  input  logic [AW-1:0] ext_addr_i,
  input  logic [AW-1:0] rpt_addr_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    unique case (src_i)
      SRC_LOAD: addr_d = ext_addr_i;
      SRC_INC:  addr_d = addr_q + AW'(1); // wraps naturally
      SRC_RPT:  addr_d = rpt_addr_i;
      default:  addr_d = addr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else         addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr
  import bac_pkg::*;
#(
  parameter int AW = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ext_addr_i,
  input  logic          ads_ni,
  input  logic          cnt_en_ni,
  input  logic          rpt_ni,
  output logic [AW-1:0] addr_o,
  output logic          rpt_err_o
);
  addr_src_e     src;
  logic [AW-1:0] rpt_addr;
  logic          rpt_valid;

  bac_src_sel i_src_sel (
    .ads_ni    (ads_ni),
    .cnt_en_ni (cnt_en_ni),
    .rpt_ni    (rpt_ni),
    .src_o     (src)
  );

  bac_rpt_reg #(.AW(AW)) i_rpt_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (src == SRC_LOAD),
    .rpt_req_i  (src == SRC_RPT),
    .ext_addr_i (ext_addr_i),
    .rpt_addr_o (rpt_addr),
    .valid_o    (rpt_valid),
    .err_o      (rpt_err_o)
  );

  bac_addr_reg #(.AW(AW)) i_addr_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .src_i      (src),
    .ext_addr_i (ext_addr_i),
    .rpt_addr_i (rpt_addr),
    .addr_o     (addr_o)
  );

  AST_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_ni && !ads_ni) |=> addr_o == $past(ext_addr_i)); // R1
  AST_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_ni && ads_ni && !cnt_en_ni) |=> addr_o == $past(addr_o) + AW'(1)); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_ni && ads_ni && cnt_en_ni) |=> $stable(addr_o)); // R3
  AST_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rpt_ni && rpt_valid) |=> addr_o == $past(rpt_addr)); // R4
  AST_LOAD_SAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_ni && !ads_ni) |=> rpt_valid && rpt_addr == $past(ext_addr_i)); // R5
  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rpt_ni && !rpt_valid) |=> rpt_err_o); // R6
  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rpt_ni || rpt_valid) |=> !rpt_err_o); // R6
  AST_RST_ERR: assert property (@(posedge clk_i)
    !rst_ni |-> !rpt_err_o); // R7
endmodule

// File: tb/test_burst_addr_ctr.sv
module test_burst_addr_ctr;
  localparam int AW = 19;
  localparam logic [AW-1:0] ONES = '1;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic          ads_n = 1'b1, cnt_n = 1'b1, rpt_n = 1'b1;
  logic [AW-1:0] addr;
  logic          err;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // scoreboard queues
  logic [AW-1:0] q_addr[$];
  logic          q_err[$];
  bit            q_chk[$];
  string         q_tag[$];

  // reference model
  logic [AW-1:0] m_addr = '0, m_rpt = '0;
  bit            m_valid = 1'b0;

  always #10 clk = ~clk;

  burst_addr_ctr #(.AW(AW)) i_burst_addr_ctr (
    .clk_i(clk), .rst_ni(rst_ni), .ext_addr_i(ext_addr),
    .ads_ni(ads_n), .cnt_en_ni(cnt_n), .rpt_ni(rpt_n),
    .addr_o(addr), .rpt_err_o(err)
  );

  task automatic step(input logic a, input logic c, input logic r,
                      input logic [AW-1:0] x, input string tag);
    logic e;
    bit   ca;
    @(negedge clk);
    ads_n = a; cnt_n = c; rpt_n = r; ext_addr = x;
    ca = 1'b1;
    e  = 1'b0;
    if (!r) begin
      if (m_valid) m_addr = m_rpt;
      else begin e = 1'b1; ca = 1'b0; end
    end else if (!a) begin
      m_addr = x; m_rpt = x; m_valid = 1'b1;
    end else if (!c) begin
      m_addr = m_addr + AW'(1);
    end
    q_addr.push_back(m_addr); q_err.push_back(e);
    q_chk.push_back(ca); q_tag.push_back(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; ads_n = 1'b1; cnt_n = 1'b1; rpt_n = 1'b1;
    m_valid = 1'b0;
    #3;
    checks++;
    if (err !== 1'b0) begin
      failures++;
      $display("FAIL R7 err under reset act=%b exp=0", err);
    end
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_ni && q_addr.size() > 0) begin
        logic [AW-1:0] ea;
        logic          ee;
        bit            ca;
        string         t;
        ea = q_addr.pop_front(); ee = q_err.pop_front();
        ca = q_chk.pop_front();  t = q_tag.pop_front();
        checks++;
        if (err !== ee) begin
          failures++;
          $display("FAIL %s err act=%b exp=%b", t, err, ee);
        end
        if (ca) begin
          checks++;
          if (addr !== ea) begin
            failures++;
            $display("FAIL %s addr act=%h exp=%h", t, addr, ea);
          end
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(1, 1, 0, 19'h00AAA, "R6");     // rewind before load
    step(1, 1, 1, 19'h00AAA, "R6");     // flag drops
    step(0, 1, 1, 19'h12345, "R1");
    step(1, 0, 1, 19'h00000, "R2");
    step(1, 0, 1, 19'h00000, "R2");
    step(1, 0, 1, 19'h00000, "R2");
    step(1, 1, 1, 19'h7BEEF, "R3");     // external ignored
    step(1, 1, 1, 19'h00001, "R3");
    step(0, 0, 0, 19'h55555, "R4");     // strobe ignored under rewind
    step(1, 0, 1, 19'h00000, "R2");
    step(1, 1, 0, 19'h00000, "R4");     // still 12345
    step(0, 1, 1, ONES - 19'd1, "R5");
    step(1, 0, 1, 19'h00000, "R2");
    step(1, 0, 1, 19'h00000, "R2");     // wrap to zero
    step(1, 0, 0, 19'h00000, "R5");     // back to newest load
    step(1, 1, 1, 19'h00000, "R6");
    do_reset();
    step(1, 0, 0, 19'h00000, "R7");     // invalid again after reset
    step(0, 1, 1, 19'h0F0F0, "R1");
    step(1, 1, 0, 19'h00000, "R6");
    for (int i = 0; i < 400; i++) begin
      logic [2:0] ctl;
      ctl = 3'($urandom);
      step(ctl[0], ctl[1], ctl[2] | ($urandom_range(0, 2) != 0),
           AW'($urandom), "R1/R2/R3/R4 random");
    end
    step(1, 1, 1, 19'h00000, "R3");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule